// File: doc/BRIEF.md
# 8-bit bus processor core

A small multi-cycle processor that runs a program out of an external byte-wide memory. Every internal move goes over one shared 8-bit internal bus. Six sources can drive that bus: the program counter, the incoming memory data, register A, register B, register C and the flag byte. A decoder state machine selects at most one source in any cycle and raises the load strobes of the registers that should capture the bus. The address latch drives the memory address. The internal bus is presented as write data, and separate read and write strobes qualify each access. Memory is read combinationally during the cycle the read strobe is high. A write takes effect at the clock edge that ends the cycle in which the write strobe is high.

Registers A and B are the ALU operands, and C receives the ALU result. A three-bit test register records equal, greater-than (unsigned) and carry. It changes only when an ALU or compare instruction tells it to load, and the decoder uses it for conditional jumps. Each opcode is one byte, with the operation in bits 7:4 and a selector in bits 1:0. Instructions that take an immediate value or an address carry it in a second byte.

The states are RESET, FETCH_ADDR, FETCH_READ, DECODE, OPND_READ and MEM_XFER. The transitions are:
- RESET → FETCH_ADDR, which clears the program counter.
- FETCH_ADDR → FETCH_READ, with PC → address latch.
- FETCH_READ → DECODE, which reads memory into the instruction register and increments the PC.
- DECODE → FETCH_ADDR for one-byte instructions, which execute in DECODE itself.
- DECODE → OPND_READ for two-byte instructions, with PC → address latch.
- OPND_READ → FETCH_ADDR for immediate loads and jumps.
- OPND_READ → MEM_XFER for memory loads and stores, which latch the operand as the address.
- MEM_XFER → FETCH_ADDR.

Top module: `octet_bus_core`

## Requirements
- R1: While rst_n is low, mem_rd and mem_wr are low. After release, the first instruction byte is read from address 0 in the second cycle. A, B, C and the flags start at zero.
- R2: A one-byte instruction takes 3 cycles, an immediate load or jump 4 cycles, and a memory load or store 5 cycles. A store's write strobe is high in its fifth cycle.
- R3: At most one internal bus source is enabled in any cycle, and mem_rd and mem_wr are never high together.
- R4: 0x10 and 0x11 load the next byte into A or B. 0x20 and 0x21 load A or B from the memory address held in the next byte.
- R5: 0x30, 0x31, 0x32 and 0x33 store A, B, C or the flag byte to the address held in the next byte. The flag byte is {5'b0, carry, greater, equal}.
- R6: 0x40 to 0x43 write A+B, A−B, the low 8 bits of A×B, or A/B into C, and load the flags.
- R7: equal is A==B and greater is A>B, both unsigned. Carry is the adder carry-out for add, the borrow (A<B) for subtract, and product>255 for multiply.
- R8: Dividing by zero gives 0xFF in C and sets carry. Otherwise carry is clear after a divide.
- R9: 0x50 loads the flags as a subtract would, and leaves C unchanged.
- R10: The flags change only on 0x4x and 0x50. Loads, stores and moves leave them unchanged.
- R11: 0x60, 0x61, 0x62 and 0x63 jump to the address in the next byte if equal, greater or carry is set, or always. A jump that is not taken continues after the operand byte.
- R12: 0x70 copies C into A.
- R13: Any other opcode (0x0x, 0x8x to 0xFx) is a one-byte no-op that changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address from the address latch |
| mem_rdata | input | 8 | Memory read data, valid while mem_rd is high |
| mem_wdata | output | 8 | Internal bus value, written when mem_wr is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
A decoder that chooses a wrong successor state shifts every later bus access. The cycle in which a store's write strobe appears therefore exposes the fault at the ports within the same instruction. A wrong register or flag value becomes visible only when a store writes it out or a conditional jump picks a path. For this reason each program ends by storing C, A or the flag byte to fixed addresses, and the written data are compared with values computed in the bench. Programs with random operands and forced zero divisors cover the ALU corners. Compare-and-jump programs with small operands hit the equal case often.

// File: rtl/obc_pkg.sv
package obc_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_DECODE,
        ST_OPND_READ,
        ST_MEM_XFER
    } cpu_state_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_DIV
    } alu_op_e;

    // operation nibble of the opcode byte
    localparam logic [3:0] OPC_LDI = 4'h1;
    localparam logic [3:0] OPC_LDM = 4'h2;
    localparam logic [3:0] OPC_ST  = 4'h3;
    localparam logic [3:0] OPC_ALU = 4'h4;
    localparam logic [3:0] OPC_CMP = 4'h5;
    localparam logic [3:0] OPC_JMP = 4'h6;
    localparam logic [3:0] OPC_MOV = 4'h7;

    // internal bus sources
    localparam int unsigned NUM_DRV = 6;
    localparam int unsigned DRV_PC  = 0;
    localparam int unsigned DRV_MEM = 1;
    localparam int unsigned DRV_A   = 2;
    localparam int unsigned DRV_B   = 3;
    localparam int unsigned DRV_C   = 4;
    localparam int unsigned DRV_FLG = 5;

    // test register bit positions
    localparam int unsigned FLG_EQ = 0;
    localparam int unsigned FLG_GT = 1;
    localparam int unsigned FLG_CY = 2;
    localparam int unsigned FLG_W  = 3;

    typedef struct packed {
        logic [NUM_DRV-1:0] drv_en;
        logic               a_ld;
        logic               b_ld;
        logic               c_ld;
        logic               al_ld;
        logic               ir_ld;
        logic               pc_ld;
        logic               pc_inc;
        logic               pc_clr;
        logic               flg_ld;
        logic               mem_rd;
        logic               mem_wr;
        alu_op_e            alu_op;
    } ctl_t;

endpackage

// File: rtl/obc_alu.sv
module obc_alu
    import obc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  alu_op_e          op,
    output logic [W-1:0]     res,
    output logic [FLG_W-1:0] flg
);
    logic [W:0]     sum;
    logic [W:0]     diff;
    logic [2*W-1:0] prod;
    logic           carry;

    assign sum  = {1'b0, opa} + {1'b0, opb};
    assign diff = {1'b0, opa} - {1'b0, opb};
    assign prod = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};

    always_comb begin
        res   = sum[W-1:0];
        carry = sum[W];
        unique case (op)
            ALU_ADD: begin
                res   = sum[W-1:0];
                carry = sum[W];
            end
            ALU_SUB: begin
                res   = diff[W-1:0];
                carry = diff[W];
            end
            ALU_MUL: begin
                res   = prod[W-1:0];
                carry = |prod[2*W-1:W];
            end
            ALU_DIV: begin
                if (opb == '0) begin
                    res   = '1;
                    carry = 1'b1;
                end else begin
                    res   = opa / opb;
                    carry = 1'b0;
                end
            end
        endcase
    end

    always_comb begin
        flg         = '0;
        flg[FLG_EQ] = (opa == opb);
        flg[FLG_GT] = (opa > opb);
        flg[FLG_CY] = carry;
    end

endmodule

// File: rtl/obc_decoder.sv
module obc_decoder
    import obc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       opc,
    input  logic [1:0]       sel,
    input  logic [FLG_W-1:0] flg,
    output ctl_t             ctl
);
    cpu_state_e state_q;
    cpu_state_e state_d;
    logic       take;

    always_comb begin
        unique case (sel)
            2'd0: take = flg[FLG_EQ];
            2'd1: take = flg[FLG_GT];
            2'd2: take = flg[FLG_CY];
            2'd3: take = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        state_d    = state_q;
        unique case (state_q)
            ST_RESET: begin
                ctl.pc_clr = 1'b1;
                state_d    = ST_FETCH_ADDR;
            end
            ST_FETCH_ADDR: begin
                ctl.drv_en[DRV_PC] = 1'b1;
                ctl.al_ld          = 1'b1;
                state_d            = ST_FETCH_READ;
            end
            ST_FETCH_READ: begin
                ctl.mem_rd          = 1'b1;
                ctl.drv_en[DRV_MEM] = 1'b1;
                ctl.ir_ld           = 1'b1;
                ctl.pc_inc          = 1'b1;
                state_d             = ST_DECODE;
            end
            ST_DECODE: begin
                state_d = ST_FETCH_ADDR;
                case (opc)
                    OPC_LDI, OPC_LDM, OPC_ST, OPC_JMP: begin
                        ctl.drv_en[DRV_PC] = 1'b1;
                        ctl.al_ld          = 1'b1;
                        state_d            = ST_OPND_READ;
                    end
                    OPC_ALU: begin
                        ctl.alu_op = alu_op_e'(sel);
                        ctl.c_ld   = 1'b1;
                        ctl.flg_ld = 1'b1;
                    end
                    OPC_CMP: begin
                        ctl.alu_op = ALU_SUB;
                        ctl.flg_ld = 1'b1;
                    end
                    OPC_MOV: begin
                        ctl.drv_en[DRV_C] = 1'b1;
                        ctl.a_ld          = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_OPND_READ: begin
                ctl.mem_rd          = 1'b1;
                ctl.drv_en[DRV_MEM] = 1'b1;
                state_d             = ST_FETCH_ADDR;
                case (opc)
                    OPC_LDI: begin
                        ctl.a_ld   = ~sel[0];
                        ctl.b_ld   = sel[0];
                        ctl.pc_inc = 1'b1;
                    end
                    OPC_LDM, OPC_ST: begin
                        ctl.al_ld  = 1'b1;
                        ctl.pc_inc = 1'b1;
                        state_d    = ST_MEM_XFER;
                    end
                    OPC_JMP: begin
                        ctl.pc_ld  = take;
                        ctl.pc_inc = ~take;
                    end
                    default: ;
                endcase
            end
            ST_MEM_XFER: begin
                state_d = ST_FETCH_ADDR;
                if (opc == OPC_LDM) begin
                    ctl.mem_rd          = 1'b1;
                    ctl.drv_en[DRV_MEM] = 1'b1;
                    ctl.a_ld            = ~sel[0];
                    ctl.b_ld            = sel[0];
                end else begin
                    ctl.mem_wr = 1'b1;
                    unique case (sel)
                        2'd0: ctl.drv_en[DRV_A]   = 1'b1;
                        2'd1: ctl.drv_en[DRV_B]   = 1'b1;
                        2'd2: ctl.drv_en[DRV_C]   = 1'b1;
                        2'd3: ctl.drv_en[DRV_FLG] = 1'b1;
                    endcase
                end
            end
            default: state_d = ST_RESET;
        endcase
    end

    // R3
    // strobe_excl_chk
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.mem_rd && ctl.mem_wr));

endmodule

// File: rtl/octet_bus_core.sv
module octet_bus_core
    import obc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr
);
    localparam int unsigned PAD_W = W - FLG_W;

    ctl_t             ctl;
    logic [W-1:0]     bus;
    logic [W-1:0]     pc_q, al_q, ra_q, rb_q, rc_q;
    logic [5:0]       ir_q;
    logic [FLG_W-1:0] flg_q;
    logic [W-1:0]     alu_res;
    logic [FLG_W-1:0] alu_flg;
    logic [W-1:0]     src  [NUM_DRV];
    logic [W-1:0]     term [NUM_DRV];

    obc_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .opc   (ir_q[5:2]),
        .sel   (ir_q[1:0]),
        .flg   (flg_q),
        .ctl   (ctl)
    );

    obc_alu #(.W(W)) u_alu (
        .opa (ra_q),
        .opb (rb_q),
        .op  (ctl.alu_op),
        .res (alu_res),
        .flg (alu_flg)
    );

    // shared bus: gated sources ORed together
    assign src[DRV_PC]  = pc_q;
    assign src[DRV_MEM] = mem_rdata;
    assign src[DRV_A]   = ra_q;
    assign src[DRV_B]   = rb_q;
    assign src[DRV_C]   = rc_q;
    assign src[DRV_FLG] = {{PAD_W{1'b0}}, flg_q};

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        assign term[g] = src[g] & {W{ctl.drv_en[g]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < NUM_DRV; i++) bus = bus | term[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            al_q  <= '0;
            ir_q  <= '0;
            ra_q  <= '0;
            rb_q  <= '0;
            rc_q  <= '0;
            flg_q <= '0;
        end else begin
            if (ctl.pc_clr)      pc_q <= '0;
            else if (ctl.pc_ld)  pc_q <= bus;
            else if (ctl.pc_inc) pc_q <= pc_q + W'(1);
            if (ctl.al_ld)  al_q  <= bus;
            if (ctl.ir_ld)  ir_q  <= {bus[W-1 -: 4], bus[1:0]};
            if (ctl.a_ld)   ra_q  <= bus;
            if (ctl.b_ld)   rb_q  <= bus;
            if (ctl.c_ld)   rc_q  <= alu_res;
            if (ctl.flg_ld) flg_q <= alu_flg;
        end
    end

    assign mem_addr  = al_q;
    assign mem_wdata = bus;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;

    // R3
    // bus_single_drv_chk
    bus_single_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl.drv_en));

    // R1
    // pc_clear_chk
    pc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_clr |=> (pc_q == '0));

    // R10
    // flag_hold_chk
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.flg_ld |=> $stable(flg_q));

    // R9
    // c_hold_chk
    c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.c_ld |=> $stable(rc_q));

    // R2
    // wr_source_chk
    wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(ctl.drv_en) == 1));

endmodule

// File: tb/octet_bus_core_tb.sv
`timescale 1ns/1ps
module octet_bus_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       mem_rd, mem_wr;
    logic [7:0] mem [256];
    int         checks = 0;
    int         errors = 0;
    int         wp = 0;
    logic [7:0] wa [8];
    logic [7:0] wd [8];
    int         wc [8];
    int         nw = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    octet_bus_core #(.W(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    // returns {carry, greater, equal, result}
    function automatic logic [10:0] model(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0]  r;
        logic        cy;
        int unsigned p;
        case (op)
            2'd0: begin p = a + b; r = p[7:0]; cy = (p > 255); end
            2'd1: begin r = a - b; cy = (a < b); end
            2'd2: begin p = a * b; r = p[7:0]; cy = (p > 255); end
            default: begin
                if (b == 0) begin r = 8'hFF; cy = 1'b1; end
                else begin r = a / b; cy = 1'b0; end
            end
        endcase
        return {cy, (a > b), (a == b), r};
    endfunction

    function automatic logic [7:0] fbyte(input logic [10:0] m);
        return {5'b0, m[10:8]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wp = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        mem[wp] = b;
        wp++;
    endtask

    task automatic run(input int want);
        int n;
        nw = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!mem_rd && !mem_wr, "R1 strobes low in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        n = 0;
        while (nw < want && n < 400) begin
            @(negedge clk);
            n++;
            if (n == 2) chk(mem_rd && mem_addr == 8'h00, "R1 first fetch at 0", mem_addr, 0);
            if (mem_wr) begin
                wa[nw] = mem_addr;
                wd[nw] = mem_wdata;
                wc[nw] = n;
                mem[mem_addr] = mem_wdata;
                nw++;
            end
        end
        chk(nw == want, "R2 program reached its stores", nw, want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        logic [7:0]  a, b, a2, b2;
        logic [1:0]  op;
        logic [10:0] m;
        logic [10:0] m2;
        bit          tk;
        void'($urandom(32'd20240607));

        // R1: registers and flags zero after reset; R5 store timing
        clear_mem();
        emit(8'h33); emit(8'hE0);
        emit(8'h32); emit(8'hE1);
        emit(8'h30); emit(8'hE2);
        emit(8'h31); emit(8'hE3);
        run(4);
        for (int i = 0; i < 4; i++) begin
            chk(wd[i] == 8'h00, "R1 reset register value", wd[i], 0);
            chk(wa[i] == 8'hE0 + i, "R5 store address", wa[i], 8'hE0 + i);
            chk(wc[i] == 5 * (i + 1), "R2 store write cycle", wc[i], 5 * (i + 1));
        end

        // R6 R7 R8: random ALU programs with forced zero divisors
        for (int it = 0; it < 40; it++) begin
            a  = 8'($urandom);
            b  = 8'($urandom);
            op = 2'($urandom);
            if (it % 8 == 7) begin op = 2'd3; b = 8'h00; end
            m = model(op, a, b);
            clear_mem();
            emit(8'h10); emit(a);
            emit(8'h11); emit(b);
            emit(8'h40 | {6'b0, op});
            emit(8'h32); emit(8'hF0);
            emit(8'h33); emit(8'hF1);
            run(2);
            if (op == 2'd3 && b == 8'h00)
                chk(wd[0] == 8'hFF && wd[1][2], "R8 divide by zero", {wd[1], wd[0]}, 16'h04FF);
            else
                chk(wd[0] == m[7:0], "R6 ALU result", wd[0], m[7:0]);
            chk(wd[1] == fbyte(m), "R7 flag byte", wd[1], fbyte(m));
            chk(wc[0] == 16 && wc[1] == 21, "R2 instruction cycles", wc[0], 16);
        end

        // R9: compare loads flags and keeps C
        for (int it = 0; it < 6; it++) begin
            a  = 8'($urandom); b  = 8'($urandom);
            a2 = 8'($urandom % 4); b2 = 8'($urandom % 4);
            m  = model(2'd0, a, b);
            m2 = model(2'd1, a2, b2);
            clear_mem();
            emit(8'h10); emit(a);
            emit(8'h11); emit(b);
            emit(8'h40);
            emit(8'h10); emit(a2);
            emit(8'h11); emit(b2);
            emit(8'h50);
            emit(8'h32); emit(8'hF0);
            emit(8'h33); emit(8'hF1);
            run(2);
            chk(wd[0] == m[7:0], "R9 compare keeps C", wd[0], m[7:0]);
            chk(wd[1] == fbyte(m2), "R9 compare flags", wd[1], fbyte(m2));
        end

        // R10: loads do not touch flags (5-9 sets borrow only)
        clear_mem();
        emit(8'h10); emit(8'h05);
        emit(8'h11); emit(8'h09);
        emit(8'h41);
        emit(8'h10); emit(8'h09);
        emit(8'h11); emit(8'h09);
        emit(8'h70);
        emit(8'h33); emit(8'hF1);
        run(1);
        chk(wd[0] == 8'h04, "R10 flags unchanged by loads and move", wd[0], 8'h04);

        // R11: conditional jumps after compare
        for (int it = 0; it < 16; it++) begin
            a = 8'($urandom % 4);
            b = 8'($urandom % 4);
            op = 2'(it % 4);
            m = model(2'd1, a, b);
            case (op)
                2'd0: tk = m[8];
                2'd1: tk = m[9];
                2'd2: tk = m[10];
                default: tk = 1'b1;
            endcase
            clear_mem();
            emit(8'h10); emit(a);
            emit(8'h11); emit(b);
            emit(8'h50);
            emit(8'h60 | {6'b0, op}); emit(8'd13);
            emit(8'h10); emit(8'h11);
            emit(8'h30); emit(8'hF2);
            emit(8'h63); emit(8'd11);
            emit(8'h10); emit(8'h22);
            emit(8'h30); emit(8'hF2);
            emit(8'h63); emit(8'd17);
            run(1);
            chk(wd[0] == (tk ? 8'h22 : 8'h11), "R11 jump path", wd[0], tk ? 8'h22 : 8'h11);
        end

        // R12: move C into A (7*6 = 42)
        clear_mem();
        emit(8'h10); emit(8'h07);
        emit(8'h11); emit(8'h06);
        emit(8'h42);
        emit(8'h70);
        emit(8'h30); emit(8'hF3);
        run(1);
        chk(wd[0] == 8'd42, "R12 move C to A", wd[0], 42);

        // R4: loads from memory
        for (int it = 0; it < 4; it++) begin
            a = 8'($urandom); b = 8'($urandom);
            m = model(2'd0, a, b);
            clear_mem();
            mem[8'h80] = a;
            mem[8'h81] = b;
            emit(8'h20); emit(8'h80);
            emit(8'h21); emit(8'h81);
            emit(8'h40);
            emit(8'h32); emit(8'hF0);
            run(1);
            chk(wd[0] == m[7:0], "R4 memory loads", wd[0], m[7:0]);
            chk(wc[0] == 18, "R2 memory load cycles", wc[0], 18);
        end

        // R13: unused opcodes are one-byte no-ops
        clear_mem();
        emit(8'h10); emit(8'h03);
        emit(8'h9A);
        emit(8'hF5);
        emit(8'h0C);
        emit(8'h30); emit(8'hF0);
        emit(8'h33); emit(8'hF1);
        run(2);
        chk(wd[0] == 8'h03, "R13 no-op keeps A", wd[0], 3);
        chk(wd[1] == 8'h00, "R13 no-op keeps flags", wd[1], 0);
        chk(wc[0] == 18, "R13 no-op takes three cycles", wc[0], 18);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule